// File: doc/BRIEF.md
# Compressed Writeback Placement Controller

This block chooses the destination of a dirty line that is being written back into a compressed page, and it produces the page's updated metadata. Each request supplies the line index, the line's new compressed size in bytes (0 to 64), and the page's current metadata. The metadata consists of the free bytes left in the overflow area, the number of allocated 512-byte chunks with their pointers, a 2-bit size class for each line, and a set of overflow slots. Each overflow slot has a used bit and a line ID.

The controller returns one of four actions:

- rewrite the line in its present slot;
- place the line in the overflow area at the end of the page;
- obtain one more chunk from an external allocator and then place the line in the overflow area;
- hand the page to recompaction.

While it waits for the allocator to answer, the controller holds off new requests. A request takes one cycle when no chunk is needed. When a chunk is needed, it takes one cycle plus the time the allocator needs to answer.

Top module: `wb_place_ctrl`

## Requirements
- R1: The new size class is the smallest class that can hold the compressed size. Class code 0 means 0 bytes, 1 means 8 bytes, 2 means 32 bytes and 3 means 64 bytes. The line's field in `md_cls_o` is bits [2*line+1:2*line]. Whenever the line is moved, the new class is written into this field.
- R2: If the new class code is not larger than the line's current code, `act` is 0 (in place) and all metadata outputs equal their inputs.
- R3: If the line does not fit, a free overflow slot exists and the free space is at least the new class size, then `act` is 1. The lowest-indexed free slot is taken: its used bit is set, and its ID field (`md_id_o` bits [6*slot+5:6*slot]) receives the line. The free space is reduced by the class size.
- R4: If the line does not fit, a slot is free, the free space is too small and fewer than 8 chunks are held, then `alloc_req` is raised. On `alloc_gnt` the following happens together: `alloc_ptr` is written at pointer index equal to the old chunk count (`md_ptrs_o` bits [32*n+31:32*n]), the count increases by 1, the line is placed as in R3, the free space becomes free + 512 − class size, and `act` is 2.
- R5: If the line does not fit and either no overflow slot is free, or the space is short while 8 chunks are already held, then `act` is 3 (recompact). Below 8 chunks, one chunk is requested first. When that chunk is granted, it is appended as in R4 and the free space grows by 512.
- R6: A line that already sits in an overflow slot and still fits its class is rewritten in place. Its slot fields are left unchanged.
- R7: A line that already sits in an overflow slot and outgrows its class gives up its old slot before a new slot is chosen.
- R8: While a chunk answer is pending, `req_ready` is low, and `alloc_req` is high only in that state. `done` pulses for one cycle with the result.
- R9: A denied chunk request ends with `act` 3. The chunk count, the pointers, the free space and the overflow slots are returned unchanged.
- R10: After reset, `req_ready` is 1, while `done` and `alloc_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Writeback request |
| req_ready | output | 1 | Controller can accept a request |
| req_line | input | 6 | Line index within the page |
| req_size | input | 7 | New compressed size in bytes |
| md_free_i | input | 13 | Free bytes in the overflow area |
| md_nchk_i | input | 4 | Chunks held by the page |
| md_ptrs_i | input | 256 | Chunk pointers, 32 bits each |
| md_cls_i | input | 128 | Size class per line |
| md_used_i | input | 17 | Overflow slot used bits |
| md_id_i | input | 102 | Overflow slot line IDs |
| alloc_req | output | 1 | Chunk request |
| alloc_gnt | input | 1 | Chunk granted |
| alloc_deny | input | 1 | Chunk refused |
| alloc_ptr | input | 32 | Pointer of the granted chunk |
| done | output | 1 | Result valid for one cycle |
| act | output | 2 | Chosen action, 0 to 3 |
| md_free_o | output | 13 | Updated free bytes |
| md_nchk_o | output | 4 | Updated chunk count |
| md_ptrs_o | output | 256 | Updated chunk pointers |
| md_cls_o | output | 128 | Updated size classes |
| md_used_o | output | 17 | Updated slot used bits |
| md_id_o | output | 102 | Updated slot IDs |

## Verification
The main decision is exercised with these sizes:

- sizes that sit exactly on class edges (0, 8, 9, 32, 33, 64) against current classes just above and just below them;
- free space that is exactly equal to the need and one class short of it;
- slot sets that are empty, partly full and full;
- chunk counts below and at the maximum.

Together these separate the four actions from one another and expose any off-by-one error in class rounding or in the space comparison. The chunk paths are driven with both a grant and a refusal, so that the two outcomes can be told apart. Lines already held in the overflow area are tried both with a shrinking size and with a growing one, which shows whether the controller locates the existing slot and releases it.

// File: rtl/wb_place_ctrl.sv
module wb_place_ctrl #(
  parameter int NLINES  = 64,
  parameter int NOVF    = 17,
  parameter int NCHUNK  = 8,
  parameter int PTR_W   = 32,
  parameter int CHUNK_B = 512,
  localparam int LN_W = $clog2(NLINES),
  localparam int CN_W = $clog2(NCHUNK + 1),
  localparam int FR_W = $clog2(NCHUNK * CHUNK_B + 1),
  localparam int SL_W = $clog2(NOVF)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LN_W-1:0]         req_line,
  input  logic [6:0]              req_size,
  input  logic [FR_W-1:0]         md_free_i,
  input  logic [CN_W-1:0]         md_nchk_i,
  input  logic [NCHUNK*PTR_W-1:0] md_ptrs_i,
  input  logic [2*NLINES-1:0]     md_cls_i,
  input  logic [NOVF-1:0]         md_used_i,
  input  logic [NOVF*LN_W-1:0]    md_id_i,
  output logic                    alloc_req,
  input  logic                    alloc_gnt,
  input  logic                    alloc_deny,
  input  logic [PTR_W-1:0]        alloc_ptr,
  output logic                    done,
  output logic [1:0]              act,
  output logic [FR_W-1:0]         md_free_o,
  output logic [CN_W-1:0]         md_nchk_o,
  output logic [NCHUNK*PTR_W-1:0] md_ptrs_o,
  output logic [2*NLINES-1:0]     md_cls_o,
  output logic [NOVF-1:0]         md_used_o,
  output logic [NOVF*LN_W-1:0]    md_id_o
);

  localparam logic [1:0] A_INPL = 2'd0, A_OVF = 2'd1, A_ALLOC = 2'd2, A_RECMP = 2'd3;

  logic            waiting;
  logic [1:0]      new_cls, cur_cls;
  logic [FR_W-1:0] need;
  logic            fits, short, at_max;
  logic [NOVF-1:0] old_mask, used_eff, slot_mask;
  logic            slot_hit;
  logic [SL_W-1:0] slot;

  logic            pend_ovf;
  logic [SL_W-1:0] pend_slot;
  logic [NOVF-1:0] pend_used;
  logic [FR_W-1:0] pend_need;
  logic [LN_W-1:0] pend_line;

  assign req_ready = !waiting;
  assign alloc_req = waiting;

  assign new_cls = (req_size == 7'd0) ? 2'd0 : (req_size <= 7'd8) ? 2'd1 :
                   (req_size <= 7'd32) ? 2'd2 : 2'd3;
  assign cur_cls = md_cls_i[2*req_line +: 2];
  assign need    = (new_cls == 2'd0) ? FR_W'(0) : (new_cls == 2'd1) ? FR_W'(8) :
                   (new_cls == 2'd2) ? FR_W'(32) : FR_W'(64);
  assign fits    = new_cls <= cur_cls;
  assign short   = md_free_i < need;
  assign at_max  = md_nchk_i == CN_W'(NCHUNK);

  always_comb begin
    old_mask = '0;
    for (int i = 0; i < NOVF; i++)
      if (md_used_i[i] && md_id_i[i*LN_W +: LN_W] == req_line && old_mask == '0)
        old_mask[i] = 1'b1;
  end

  assign used_eff = md_used_i & ~old_mask;

  always_comb begin
    slot_hit = 1'b0;
    slot     = '0;
    for (int i = NOVF - 1; i >= 0; i--)
      if (!used_eff[i]) begin
        slot_hit = 1'b1;
        slot     = SL_W'(i);
      end
  end

  assign slot_mask = NOVF'(1) << slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      done      <= 1'b0;
      act       <= A_INPL;
      md_free_o <= '0;
      md_nchk_o <= '0;
      md_ptrs_o <= '0;
      md_cls_o  <= '0;
      md_used_o <= '0;
      md_id_o   <= '0;
      pend_ovf  <= 1'b0;
      pend_slot <= '0;
      pend_used <= '0;
      pend_need <= '0;
      pend_line <= '0;
    end else begin
      done <= 1'b0;
      if (!waiting && req_valid) begin
        md_free_o <= md_free_i;
        md_nchk_o <= md_nchk_i;
        md_ptrs_o <= md_ptrs_i;
        md_cls_o  <= md_cls_i;
        md_used_o <= md_used_i;
        md_id_o   <= md_id_i;
        pend_slot <= slot;
        pend_used <= used_eff | slot_mask;
        pend_need <= need;
        pend_line <= req_line;
        if (!fits) md_cls_o[2*req_line +: 2] <= new_cls;
        if (fits) begin
          act  <= A_INPL;
          done <= 1'b1;
        end else if (slot_hit && !short) begin
          act       <= A_OVF;
          done      <= 1'b1;
          md_used_o <= used_eff | slot_mask;
          md_id_o[slot*LN_W +: LN_W] <= req_line;
          md_free_o <= md_free_i - need;
        end else if (!at_max) begin
          waiting  <= 1'b1;
          pend_ovf <= slot_hit;
        end else begin
          act  <= A_RECMP;
          done <= 1'b1;
        end
      end else if (waiting && alloc_gnt) begin
        waiting   <= 1'b0;
        done      <= 1'b1;
        md_ptrs_o[PTR_W*md_nchk_o +: PTR_W] <= alloc_ptr;
        md_nchk_o <= md_nchk_o + 1'b1;
        if (pend_ovf) begin
          act       <= A_ALLOC;
          md_used_o <= pend_used;
          md_id_o[pend_slot*LN_W +: LN_W] <= pend_line;
          md_free_o <= md_free_o + FR_W'(CHUNK_B) - pend_need;
        end else begin
          act       <= A_RECMP;
          md_free_o <= md_free_o + FR_W'(CHUNK_B);
        end
      end else if (waiting && alloc_deny) begin
        waiting <= 1'b0;
        done    <= 1'b1;
        act     <= A_RECMP;
      end
    end
  end

endmodule

// File: rtl/wb_place_ctrl_chk.sv
module wb_place_ctrl_chk #(
  parameter int NLINES = 64,
  parameter int NCHUNK = 8,
  localparam int LN_W = $clog2(NLINES),
  localparam int CN_W = $clog2(NCHUNK + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LN_W-1:0]   req_line,
  input logic [6:0]        req_size,
  input logic [2*NLINES-1:0] md_cls_i,
  input logic              alloc_req,
  input logic              alloc_gnt,
  input logic              alloc_deny,
  input logic              done,
  input logic [1:0]        act,
  input logic [CN_W-1:0]   md_nchk_o
);

  logic [1:0] cur_code;
  logic       small_enough;

  assign cur_code = md_cls_i[2*req_line +: 2];
  assign small_enough = (cur_code == 2'd3) ||
                        (cur_code == 2'd2 && req_size < 7'd33) ||
                        (cur_code == 2'd1 && req_size < 7'd9) ||
                        (req_size == 7'd0);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> !req_ready);

  assert_idle_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !alloc_req);

  assert_inplace_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && small_enough) |=> (done && act == 2'd0));

  assert_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_gnt) |=> (done && md_nchk_o <= CN_W'(NCHUNK) && md_nchk_o != '0));

  assert_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_deny && !alloc_gnt) |=> (done && act == 2'd3));

endmodule

bind wb_place_ctrl wb_place_ctrl_chk #(.NLINES(NLINES), .NCHUNK(NCHUNK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_line(req_line), .req_size(req_size), .md_cls_i(md_cls_i),
  .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_deny(alloc_deny),
  .done(done), .act(act), .md_nchk_o(md_nchk_o)
);

// File: tb/wb_place_ctrl_tb.sv
`timescale 1ns/1ps
module wb_place_ctrl_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [5:0]   req_line = '0;
  logic [6:0]   req_size = '0;
  logic [12:0]  md_free_i = '0;
  logic [3:0]   md_nchk_i = '0;
  logic [255:0] md_ptrs_i = '0;
  logic [127:0] md_cls_i = '0;
  logic [16:0]  md_used_i = '0;
  logic [101:0] md_id_i = '0;
  logic         alloc_req;
  logic         alloc_gnt = 1'b0;
  logic         alloc_deny = 1'b0;
  logic [31:0]  alloc_ptr = '0;
  logic         done;
  logic [1:0]   act;
  logic [12:0]  md_free_o;
  logic [3:0]   md_nchk_o;
  logic [255:0] md_ptrs_o;
  logic [127:0] md_cls_o;
  logic [16:0]  md_used_o;
  logic [101:0] md_id_o;

  always #2.5 clk = ~clk;

  wb_place_ctrl u_dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  logic saw;

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", rq, got, exp);
    end
  endtask

  task automatic setup(input int cur5, input int free, input int nchk, input logic full);
    md_cls_i = {64{2'd2}};
    md_cls_i[11:10] = 2'(cur5);
    md_free_i = 13'(free);
    md_nchk_i = 4'(nchk);
    md_ptrs_i = '0;
    md_used_i = full ? '1 : '0;
    md_id_i = '0;
  endtask

  task automatic do_req(input int ln, input int sz, input int gm, input logic [31:0] ptr,
                        output logic seen);
    req_line = 6'(ln);
    req_size = 7'(sz);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = alloc_req;
    if (alloc_req) begin
      chk("R8 ready low while waiting", {31'd0, req_ready}, 32'd0);
      alloc_ptr = ptr;
      alloc_gnt = (gm == 1);
      alloc_deny = (gm != 1);
      @(negedge clk);
      alloc_gnt = 1'b0;
      alloc_deny = 1'b0;
    end
    chk("R8 done pulse", {31'd0, done}, 32'd1);
  endtask

  typedef struct packed {
    logic [6:0]  sz;
    logic [1:0]  cur;
    logic [12:0] free;
    logic [3:0]  nchk;
    logic        full;
    logic [1:0]  gm;
    logic [1:0]  eact;
    logic [12:0] efree;
    logic [3:0]  enchk;
    logic        ereq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{7'd20, 2'd2, 13'd100, 4'd4, 1'b0, 2'd0, 2'd0, 13'd100, 4'd4, 1'b0},
    '{7'd0,  2'd0, 13'd100, 4'd4, 1'b0, 2'd0, 2'd0, 13'd100, 4'd4, 1'b0},
    '{7'd33, 2'd2, 13'd100, 4'd4, 1'b0, 2'd0, 2'd1, 13'd36,  4'd4, 1'b0},
    '{7'd9,  2'd1, 13'd20,  4'd4, 1'b0, 2'd1, 2'd2, 13'd500, 4'd5, 1'b1},
    '{7'd9,  2'd1, 13'd20,  4'd4, 1'b0, 2'd2, 2'd3, 13'd20,  4'd4, 1'b1},
    '{7'd64, 2'd2, 13'd10,  4'd8, 1'b0, 2'd0, 2'd3, 13'd10,  4'd8, 1'b0},
    '{7'd40, 2'd2, 13'd300, 4'd4, 1'b1, 2'd1, 2'd3, 13'd812, 4'd5, 1'b1},
    '{7'd40, 2'd2, 13'd300, 4'd8, 1'b1, 2'd0, 2'd3, 13'd300, 4'd8, 1'b0},
    '{7'd1,  2'd0, 13'd8,   4'd4, 1'b0, 2'd0, 2'd1, 13'd0,   4'd4, 1'b0},
    '{7'd64, 2'd3, 13'd0,   4'd4, 1'b0, 2'd0, 2'd0, 13'd0,   4'd4, 1'b0}
  };

  initial begin
    #(5.0 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R10 done after reset", {31'd0, done}, 32'd0);
    chk("R10 alloc_req after reset", {31'd0, alloc_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R2 in place, R3 overflow, R4 grant, R5 recompact, R9 deny
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].cur, VECS[i].free, VECS[i].nchk, VECS[i].full);
      do_req(5, VECS[i].sz, VECS[i].gm, 32'h1000 + i, saw);
      chk($sformatf("R2/R3/R4/R5/R9 act v%0d", i), {30'd0, act}, {30'd0, VECS[i].eact});
      chk($sformatf("R3/R4/R5 free v%0d", i), {19'd0, md_free_o}, {19'd0, VECS[i].efree});
      chk($sformatf("R4/R5 nchk v%0d", i), {28'd0, md_nchk_o}, {28'd0, VECS[i].enchk});
      chk($sformatf("R4/R5 request v%0d", i), {31'd0, saw}, {31'd0, VECS[i].ereq});
      @(negedge clk);
    end

    // R1 rounding and R3 slot record
    setup(2, 100, 4, 1'b0);
    do_req(5, 33, 0, 0, saw);
    chk("R1 class of 33 bytes", {30'd0, md_cls_o[11:10]}, 32'd3);
    chk("R3 slot 0 used", {15'd0, md_used_o}, 32'd1);
    chk("R3 slot 0 id", {26'd0, md_id_o[5:0]}, 32'd5);
    @(negedge clk);
    setup(0, 100, 4, 1'b0);
    do_req(5, 8, 0, 0, saw);
    chk("R1 class of 8 bytes", {30'd0, md_cls_o[11:10]}, 32'd1);
    @(negedge clk);
    setup(1, 100, 4, 1'b0);
    do_req(5, 9, 0, 0, saw);
    chk("R1 class of 9 bytes", {30'd0, md_cls_o[11:10]}, 32'd2);
    chk("R3 free after 32B", {19'd0, md_free_o}, 32'd68);
    @(negedge clk);

    // R3 lowest free slot
    setup(2, 100, 4, 1'b0);
    md_used_i = 17'h7;
    do_req(5, 40, 0, 0, saw);
    chk("R3 slot 3 taken", {15'd0, md_used_o}, 32'hF);
    chk("R3 slot 3 id", {26'd0, md_id_o[23:18]}, 32'd5);
    @(negedge clk);

    // R6 line in overflow that still fits
    setup(2, 100, 4, 1'b0);
    md_used_i = 17'h8;
    md_id_i[23:18] = 6'd7;
    md_cls_i[15:14] = 2'd1;
    do_req(7, 5, 0, 0, saw);
    chk("R6 act in place", {30'd0, act}, 32'd0);
    chk("R6 slots unchanged", {15'd0, md_used_o}, 32'h8);
    chk("R6 id unchanged", {26'd0, md_id_o[23:18]}, 32'd7);
    @(negedge clk);

    // R7 line in overflow that grows
    do_req(7, 30, 0, 0, saw);
    chk("R7 act overflow", {30'd0, act}, 32'd1);
    chk("R7 old slot released", {15'd0, md_used_o}, 32'h1);
    chk("R7 new slot id", {26'd0, md_id_o[5:0]}, 32'd7);
    chk("R7 free", {19'd0, md_free_o}, 32'd68);
    @(negedge clk);

    // R4 pointer append
    setup(1, 20, 4, 1'b0);
    md_ptrs_i[31:0] = 32'h5555AAAA;
    do_req(5, 9, 1, 32'hABCD1234, saw);
    chk("R4 pointer at index 4", md_ptrs_o[159:128], 32'hABCD1234);
    chk("R4 pointer 0 kept", md_ptrs_o[31:0], 32'h5555AAAA);
    chk("R4 slot placed", {15'd0, md_used_o}, 32'h1);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);

    // R9 deny leaves slots and pointers
    setup(1, 20, 4, 1'b0);
    do_req(5, 9, 2, 32'hFFFF0000, saw);
    chk("R9 slots untouched", {15'd0, md_used_o}, 32'h0);
    chk("R9 pointer untouched", md_ptrs_o[159:128], 32'h0);
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule